// File: doc/BRIEF.md
# Masked Content-Search Table with Occupancy Flags

This block is a small table that is searched by content rather than by location. Each of its CELLS entries holds a WIDTH-bit word and one occupancy flag. A search presents a query word and a mask. Every entry is compared in the same cycle, and only the bit positions selected by the mask take part. The block reports whether no entry, one entry or several entries matched, how many matched, and the lowest index among them.

A read performs the same search and also returns the word stored at the lowest matching index. When nothing matches, the read is cancelled. A write finds the lowest free entry by running the same masked comparison against the occupancy flag alone. It stores the new word there and marks the entry as occupied. When no entry is free, the write is refused and a full indication is raised. A delete frees one entry, selected by its index.

One operation is accepted per clock on a single strobe. Its results appear on the registered outputs one clock later. All operations are fully pipelined, so operations may be issued back to back.

Top module: `assoc_mem`

## Requirements
- R1: Reset clears every occupancy flag, so a search issued after reset with an all-zero mask reports no match (hit_none=1, hit_count=0).
- R2: An occupied entry matches when, for every bit position where mask is 1, the stored bit equals the query bit. Positions where mask is 0 are ignored.
- R3: Exactly one of hit_none, hit_one and hit_many is 1 at any time. They indicate zero, exactly one, or two or more matching entries.
- R4: hit_count equals the number of entries that matched in the latest search, read or write.
- R5: A search or read never matches an entry whose occupancy flag is 0, even if the entry still holds stale data that would otherwise match.
- R6: A read with at least one match sets rd_valid=1 and returns, on rdata, the word at the lowest matching index. That index is also reported on hit_idx. A read with no match sets rd_valid=0 and rdata=0.
- R7: A write stores wdata in the lowest-numbered free entry and sets that entry's flag. hit_idx reports the entry, and hit_count reports the number of entries that were free before the write.
- R8: A write with no free entry changes nothing in the table, sets full=1 and reports hit_none=1.
- R9: A delete clears the flag of entry del_idx. The result outputs (hit_* and rdata/rd_valid) keep their previous values.
- R10: op codes are 0=search, 1=read, 2=write, 3=delete. done is 1 in the clock after op_valid is sampled high, and 0 otherwise. Each operation's results are valid while done is 1.
- R11: full changes only on a write. A successful write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op | input | 2 | 0 search, 1 read, 2 write, 3 delete |
| query | input | WIDTH | Search word |
| mask | input | WIDTH | Compare-enable per bit position |
| wdata | input | WIDTH | Word to store on write |
| del_idx | input | IDXW | Entry to free on delete |
| done | output | 1 | Results valid for the previous strobe |
| hit_none | output | 1 | No entry matched |
| hit_one | output | 1 | Exactly one entry matched |
| hit_many | output | 1 | Two or more entries matched |
| hit_count | output | CNTW | Number of matching entries |
| hit_idx | output | IDXW | Lowest matching (or allocated) index |
| rd_valid | output | 1 | Read found a word |
| rdata | output | WIDTH | Word returned by read |
| full | output | 1 | Last write was refused for lack of space |

## Verification
The bench uses the default of eight entries of eight bits. This size lets a short sequence fill the table completely and reach the refused-write case. It also lets a delete open one slot inside the table, so that the next write must take that slot rather than the end. The word values are chosen so that partial masks select two entries at once and a full mask selects one, which brings the zero, one and several summaries all within reach. A deleted entry whose stale data still matches the query shows that free entries are excluded from searches.

// File: rtl/assoc_mem_pkg.sv
package assoc_mem_pkg;

    typedef enum logic [1:0] {
        OP_SEARCH = 2'd0,
        OP_READ   = 2'd1,
        OP_WRITE  = 2'd2,
        OP_DELETE = 2'd3
    } op_e;

endpackage

// File: rtl/am_match_array.sv
module am_match_array #(
    parameter int CELLS = 8,
    parameter int BITS  = 9
) (
    input  logic [CELLS-1:0][BITS-1:0] cells,
    input  logic [BITS-1:0]            key,
    input  logic [BITS-1:0]            care,
    input  logic                       need_occ,
    output logic [CELLS-1:0]           hits
);

    for (genvar j = 0; j < CELLS; j++) begin : g_cell
        logic agree;
        assign agree   = ((cells[j] ^ key) & care) == '0;
        assign hits[j] = agree && (!need_occ || cells[j][BITS-1]);
    end

endmodule

// File: rtl/am_first_one.sv
module am_first_one #(
    parameter int N    = 8,
    parameter int IDXW = 3
) (
    input  logic [N-1:0]    vec,
    output logic [IDXW-1:0] idx,
    output logic            any
);

    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDXW'(i);
        end
    end

endmodule

// File: rtl/am_ones_count.sv
module am_ones_count #(
    parameter int N    = 8,
    parameter int CNTW = 4
) (
    input  logic [N-1:0]    vec,
    output logic [CNTW-1:0] cnt
);

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CNTW'(vec[i]);
        end
    end

endmodule

// File: rtl/assoc_mem.sv
module assoc_mem
    import assoc_mem_pkg::*;
#(
    parameter  int CELLS = 8,
    parameter  int WIDTH = 8,
    localparam int IDXW  = (CELLS > 1) ? $clog2(CELLS) : 1,
    localparam int CNTW  = $clog2(CELLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] query,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDXW-1:0]  del_idx,
    output logic             done,
    output logic             hit_none,
    output logic             hit_one,
    output logic             hit_many,
    output logic [CNTW-1:0]  hit_count,
    output logic [IDXW-1:0]  hit_idx,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rdata,
    output logic             full
);

    localparam int CW = WIDTH + 1;

    typedef struct packed {
        logic [CELLS-1:0][WIDTH-1:0] data;
        logic [CELLS-1:0]            occ;
        logic                        done;
        logic                        none;
        logic                        one;
        logic                        many;
        logic [CNTW-1:0]             cnt;
        logic [IDXW-1:0]             idx;
        logic                        rd_valid;
        logic [WIDTH-1:0]            rdata;
        logic                        full;
    } state_t;

    state_t st_d, st_q;

    op_e                         op_sel;
    logic                        alloc;
    logic [CELLS-1:0][CW-1:0]    cell_words;
    logic [CW-1:0]               cmp_key;
    logic [CW-1:0]               cmp_care;
    logic [CELLS-1:0]            hit_vec;
    logic [IDXW-1:0]             first_idx;
    logic                        first_any;
    logic [CNTW-1:0]             hit_cnt;

    assign op_sel = op_e'(op);
    assign alloc  = (op_sel == OP_WRITE);

    always_comb begin
        for (int j = 0; j < CELLS; j++) begin
            cell_words[j] = {st_q.occ[j], st_q.data[j]};
        end
        if (alloc) begin
            cmp_key  = {1'b0, {WIDTH{1'b1}}};
            cmp_care = {1'b1, {WIDTH{1'b0}}};
        end else begin
            cmp_key  = {1'b1, query};
            cmp_care = {1'b0, mask};
        end
    end

    am_match_array #(.CELLS(CELLS), .BITS(CW)) u_match (
        .cells    (cell_words),
        .key      (cmp_key),
        .care     (cmp_care),
        .need_occ (!alloc),
        .hits     (hit_vec)
    );

    am_first_one #(.N(CELLS), .IDXW(IDXW)) u_first (
        .vec (hit_vec),
        .idx (first_idx),
        .any (first_any)
    );

    am_ones_count #(.N(CELLS), .CNTW(CNTW)) u_count (
        .vec (hit_vec),
        .cnt (hit_cnt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (op_valid) begin
            st_d.done = 1'b1;
            if (op_sel == OP_DELETE) begin
                if (32'(del_idx) < CELLS) st_d.occ[del_idx] = 1'b0;
            end else begin
                st_d.none     = (hit_cnt == '0);
                st_d.one      = (hit_cnt == CNTW'(1));
                st_d.many     = (hit_cnt > CNTW'(1));
                st_d.cnt      = hit_cnt;
                st_d.idx      = first_any ? first_idx : '0;
                st_d.rd_valid = 1'b0;
                st_d.rdata    = '0;
                if (op_sel == OP_READ && first_any) begin
                    st_d.rd_valid = 1'b1;
                    st_d.rdata    = st_q.data[first_idx];
                end
                if (alloc) begin
                    if (first_any) begin
                        st_d.data[first_idx] = wdata;
                        st_d.occ[first_idx]  = 1'b1;
                        st_d.full            = 1'b0;
                    end else begin
                        st_d.full = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.none <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign done      = st_q.done;
    assign hit_none  = st_q.none;
    assign hit_one   = st_q.one;
    assign hit_many  = st_q.many;
    assign hit_count = st_q.cnt;
    assign hit_idx   = st_q.idx;
    assign rd_valid  = st_q.rd_valid;
    assign rdata     = st_q.rdata;
    assign full      = st_q.full;

endmodule

// File: rtl/assoc_mem_chk.sv
module assoc_mem_chk #(
    parameter int IDXW = 3,
    parameter int CNTW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [1:0]      op,
    input logic            done,
    input logic            hit_none,
    input logic            hit_one,
    input logic            hit_many,
    input logic [CNTW-1:0] hit_count,
    input logic            rd_valid,
    input logic            full
);

    a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done);

    a_r3_one_summary: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({hit_none, hit_one, hit_many}));

    a_r4_count_single: assert property (@(posedge clk) disable iff (!rst_n)
        hit_one |-> hit_count == CNTW'(1));

    a_r4_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hit_none |-> hit_count == '0);

    a_r6_rd_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !hit_none);

    a_r8_full_on_refusal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> hit_none && $past(op_valid && op == 2'd2));

    a_r11_full_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op == 2'd2) |=> $stable(full));

    a_r9_delete_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 2'd3) |=> $stable(hit_count) && $stable(rd_valid));

endmodule

bind assoc_mem assoc_mem_chk #(.IDXW(IDXW), .CNTW(CNTW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op        (op),
    .done      (done),
    .hit_none  (hit_none),
    .hit_one   (hit_one),
    .hit_many  (hit_many),
    .hit_count (hit_count),
    .rd_valid  (rd_valid),
    .full      (full)
);

// File: tb/assoc_mem_test.sv
`timescale 1ns/1ps
module assoc_mem_test;

    localparam int CELLS = 8;
    localparam int WIDTH = 8;
    localparam int IDXW  = 3;
    localparam int CNTW  = 4;

    logic             clk = 0;
    logic             rst_n = 0;
    logic             op_valid = 0;
    logic [1:0]       op = 0;
    logic [WIDTH-1:0] query = 0, mask = 0, wdata = 0;
    logic [IDXW-1:0]  del_idx = 0;
    logic             done, hit_none, hit_one, hit_many, rd_valid, full;
    logic [CNTW-1:0]  hit_count;
    logic [IDXW-1:0]  hit_idx;
    logic [WIDTH-1:0] rdata;

    always #10 clk = ~clk;

    assoc_mem #(.CELLS(CELLS), .WIDTH(WIDTH)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
        .query(query), .mask(mask), .wdata(wdata), .del_idx(del_idx),
        .done(done), .hit_none(hit_none), .hit_one(hit_one),
        .hit_many(hit_many), .hit_count(hit_count), .hit_idx(hit_idx),
        .rd_valid(rd_valid), .rdata(rdata), .full(full)
    );

    typedef struct packed {
        logic             none;
        logic             one;
        logic             many;
        logic [CNTW-1:0]  cnt;
        logic [IDXW-1:0]  idx;
        logic             rdv;
        logic [WIDTH-1:0] rd;
        logic             fl;
    } res_t;

    res_t  exp_q[$];
    string tag_q[$];
    res_t  last;
    logic  m_occ [CELLS];
    logic [WIDTH-1:0] m_data [CELLS];
    int    n_checks = 0;
    int    n_fail = 0;

    function automatic res_t observed();
        res_t r;
        r = '{hit_none, hit_one, hit_many, hit_count, hit_idx, rd_valid, rdata, full};
        return r;
    endfunction

    task automatic check(input res_t act, input res_t exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one operation and pushes the result the requirements predict.
    task automatic do_op(input logic [1:0] o, input logic [WIDTH-1:0] q,
                         input logic [WIDTH-1:0] m, input logic [WIDTH-1:0] w,
                         input int di, input string tag);
        res_t r;
        logic hv [CELLS];
        int   cnt, first;
        @(negedge clk);
        op_valid = 1; op = o; query = q; mask = m; wdata = w; del_idx = IDXW'(di);
        r = last;
        if (o == 2'd3) begin
            m_occ[di] = 0;
        end else begin
            cnt = 0; first = -1;
            for (int j = 0; j < CELLS; j++) begin
                if (o == 2'd2) hv[j] = !m_occ[j];
                else hv[j] = m_occ[j] && (((m_data[j] ^ q) & m) == 0);
                if (hv[j]) begin
                    cnt++;
                    if (first < 0) first = j;
                end
            end
            r.none = (cnt == 0); r.one = (cnt == 1); r.many = (cnt > 1);
            r.cnt  = CNTW'(cnt);
            r.idx  = (first < 0) ? '0 : IDXW'(first);
            r.rdv  = 0; r.rd = 0;
            if (o == 2'd1 && first >= 0) begin
                r.rdv = 1; r.rd = m_data[first];
            end
            if (o == 2'd2) begin
                if (first >= 0) begin
                    m_data[first] = w; m_occ[first] = 1; r.fl = 0;
                end else begin
                    r.fl = 1;
                end
            end
        end
        last = r;
        exp_q.push_back(r);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 0;
    endtask

    // Monitor: compares each completed operation with the front of the queue.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10 done with nothing outstanding actual=1 expected=0");
            end else begin
                check(observed(), exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int j = 0; j < CELLS; j++) begin m_occ[j] = 0; m_data[j] = 0; end
        last = '0; last.none = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 R3: reset state, no result pending
        check(observed(), last, "R3 reset state");
        n_checks++;
        if (done !== 1'b0) begin n_fail++; $display("FAIL R10 done after reset actual=%b expected=0", done); end

        do_op(2'd0, 8'h00, 8'h00, 8'h00, 0, "R1 search after reset");
        do_op(2'd2, 8'h00, 8'h00, 8'h11, 0, "R7 write to entry 0");
        do_op(2'd2, 8'h00, 8'h00, 8'h22, 0, "R7 write to entry 1");
        do_op(2'd2, 8'h00, 8'h00, 8'h13, 0, "R7 write to entry 2");
        do_op(2'd2, 8'h00, 8'h00, 8'h22, 0, "R7 write to entry 3");
        do_op(2'd0, 8'h22, 8'hFF, 8'h00, 0, "R3 R4 search two hits");
        do_op(2'd1, 8'h10, 8'hF0, 8'h00, 0, "R2 R6 masked read lowest index");
        do_op(2'd1, 8'h13, 8'hFF, 8'h00, 0, "R6 read single hit");
        do_op(2'd0, 8'hF3, 8'h0F, 8'h00, 0, "R2 upper nibble ignored");
        do_op(2'd3, 8'h00, 8'h00, 8'h00, 0, "R9 delete holds results");
        do_op(2'd1, 8'h10, 8'hF0, 8'h00, 0, "R5 stale entry excluded");
        do_op(2'd2, 8'h00, 8'h00, 8'h55, 0, "R7 write reuses entry 0");
        do_op(2'd2, 8'h00, 8'h00, 8'h66, 0, "R7 write entry 4");
        do_op(2'd2, 8'h00, 8'h00, 8'h77, 0, "R7 write entry 5");
        do_op(2'd2, 8'h00, 8'h00, 8'h88, 0, "R7 write entry 6");
        do_op(2'd2, 8'h00, 8'h00, 8'h99, 0, "R7 write entry 7");
        do_op(2'd2, 8'h00, 8'h00, 8'hAA, 0, "R8 write refused when full");
        do_op(2'd0, 8'hAA, 8'hFF, 8'h00, 0, "R8 R11 refused word absent, full held");
        do_op(2'd1, 8'h99, 8'hFF, 8'h00, 0, "R8 R6 last entry intact");
        do_op(2'd3, 8'h00, 8'h00, 8'h00, 5, "R9 delete entry 5");
        do_op(2'd2, 8'h00, 8'h00, 8'hBB, 0, "R7 R11 write fills hole, full cleared");
        do_op(2'd0, 8'h00, 8'h00, 8'h00, 0, "R4 all entries match empty mask");
        do_op(2'd1, 8'hBB, 8'hFF, 8'h00, 0, "R6 read new word at 5");
        do_op(2'd1, 8'hEE, 8'hFF, 8'h00, 0, "R6 read cancelled");
        idle();
        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 results missing actual=%0d expected=0", exp_q.size());
        end
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule